// File: doc/BRIEF.md
# DAC Output Code Bank with Deferred Update

This block keeps the output codes for eight 12-bit DAC channels. Channels 0 to 3 are unipolar and channels 4 to 7 are bipolar. Every accepted write lands in the addressed channel's staging register. Two flag bits in the write word control what happens next. One flag says whether the live code that drives the converter changes at the same clock edge or waits for a load strobe. The other flag asks for the written value to go to all four bipolar channels. That broadcast is honoured only while the bank is in open-loop mode.

Each bipolar channel also holds a 2-bit output span selection. The span travels with the code: it is staged on a write and becomes live at the same moment as the code. The load strobe is an asynchronous active-low level. The bank synchronises it and acts on its falling edge. On that edge, every channel with a deferred value waiting moves the value to its live output.

The write port uses valid/ready. The bank never applies back-pressure: `wr_ready` is held high, so a write is taken on every clock edge where `wr_valid` is high. The mode input and the load strobe are plain levels.

Top module: `dac_code_bank`

## Requirements
- R1: After reset, every live code and staged code is 0x000, every pending flag is 0, and every span field reads 00.
- R2: Write word layout is: code in bits [15:4], span in bits [3:2], load flag in bit 1, copy flag in bit 0. A write with the load flag at 0 updates that channel's live code at the same clock edge and clears its pending flag.
- R3: A write with the load flag at 1 stores the code without changing the live output, and sets that channel's pending flag.
- R4: The load strobe passes through two synchronising flops. Its falling edge moves every pending channel's staged code and span to the live outputs on the third clock edge after the fall, and clears all pending flags. Keeping the strobe low afterwards causes no further transfer.
- R5: In open-loop mode (`closed_loop`=0), a write with the copy flag to a bipolar address puts the same code, span and load behaviour on all four bipolar channels.
- R6: In closed-loop mode, the copy flag is ignored and only the addressed channel changes. A copy flag on a unipolar address is always ignored.
- R7: Channel n is at address 0x30+n. Writes to any other address change no output.
- R8: If a write and a strobe transfer reach the same channel in the same cycle, the write wins for that channel. Other pending channels still transfer.
- R9: Span codes are 00 = 0 V to +5 V, 01 = -5 V to 0 V, 10 = -4 V to +1 V. Code 11 keeps the previously staged span. Unipolar span fields always read 00.
- R10: `wr_ready` is 1 in every cycle, so no write is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Always 1; write taken when valid |
| wr_addr | input | 8 | Channel address (0x30..0x37) |
| wr_data | input | 16 | Code [15:4], span [3:2], load [1], copy [0] |
| ldac_n | input | 1 | Asynchronous active-low load strobe |
| closed_loop | input | 1 | 1 = closed-loop mode, which disables the copy flag |
| code_o | output | 96 | Live codes, channel n at [12n+11:12n] |
| span_o | output | 16 | Live span, channel n at [2n+1:2n] |
| pending_o | output | 8 | Per-channel deferred-load pending flag |

## Verification
The assertions assume that `wr_addr`, `wr_data` and `closed_loop` are stable around the clock edge. They also assume that `ldac_n` is free to change at any time, because the checks look only at the synchronised edge pulse and never at the raw pin. The bench changes every input at the falling clock edge. It holds the strobe at each level for at least three cycles, so every fall is seen by the synchroniser, and it holds `closed_loop` constant throughout each write. The collision case is driven at an exact cycle: the write is lined up with the third edge after the strobe fall.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int LOAD_BIT = 1;
  localparam int COPY_BIT = 0;
  localparam int SPAN_LSB = 2;
  localparam int CODE_LSB = 4;

  typedef enum logic [1:0] {
    SPAN_POS5  = 2'b00,
    SPAN_NEG5  = 2'b01,
    SPAN_SPLIT = 2'b10,
    SPAN_KEEP  = 2'b11
  } span_e;
endpackage

// File: rtl/dac_strobe_sync.sv
module dac_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= strobe_n;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall = s3_q & ~s2_q;

  // R4
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
  parameter int N_UNI = 4,
  parameter int N_BI = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h30,
  localparam int N_CH = N_UNI + N_BI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              copy,
  input  logic              closed_loop,
  output logic [N_CH-1:0]   we
);
  localparam logic [ADDR_W-1:0] BI_LO  = ADDR_W'(BASE_ADDR + N_UNI);
  localparam logic [ADDR_W-1:0] TOP_HI = ADDR_W'(BASE_ADDR + N_CH - 1);

  logic bi_hit, bcast;
  assign bi_hit = (wr_addr >= BI_LO) && (wr_addr <= TOP_HI);
  assign bcast  = wr_valid && copy && !closed_loop && bi_hit;

  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + i);
    logic direct;
    assign direct = wr_valid && (wr_addr == MY_ADDR);
    if (i >= N_UNI) begin : g_bi
      assign we[i] = direct | bcast;
    end else begin : g_uni
      assign we[i] = direct;
    end
  end

  // R6
  closed_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    closed_loop |-> $onehot0(we));
  // R7
  miss_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_addr < BASE_ADDR) || (wr_addr > TOP_HI)) |-> (we == '0));
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg
  import dac_bank_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter bit IS_BI = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_load,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [1:0]        wr_span,
  input  logic              xfer,
  output logic [CODE_W-1:0] act_code,
  output logic [1:0]        act_span,
  output logic              pend
);
  logic [CODE_W-1:0] stg_code_q, act_code_q;
  logic [1:0]        stg_span_q, act_span_q, next_span;
  logic              pend_q;

  always_comb begin
    next_span = stg_span_q;
    if (IS_BI && (wr_span != SPAN_KEEP)) next_span = wr_span;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_code_q <= '0;
      act_code_q <= '0;
      stg_span_q <= SPAN_POS5;
      act_span_q <= SPAN_POS5;
      pend_q     <= 1'b0;
    end else if (wr_en) begin
      stg_code_q <= wr_code;
      stg_span_q <= next_span;
      if (!wr_load) begin
        act_code_q <= wr_code;
        act_span_q <= next_span;
        pend_q     <= 1'b0;
      end else begin
        pend_q     <= 1'b1;
      end
    end else if (xfer && pend_q) begin
      act_code_q <= stg_code_q;
      act_span_q <= stg_span_q;
      pend_q     <= 1'b0;
    end
  end

  assign act_code = act_code_q;
  assign act_span = act_span_q;
  assign pend     = pend_q;

  // R2
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_load) |=> (act_code_q == $past(wr_code)) && !pend_q);
  // R3
  deferred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_load) |=> $stable(act_code_q) && pend_q);
  // R4
  xfer_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && pend_q && !wr_en) |=> !pend_q && (act_code_q == $past(stg_code_q)));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !xfer) |=> $stable(act_code_q) && $stable(pend_q));
  // R9
  uni_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !IS_BI |-> (act_span_q == SPAN_POS5));
endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank
  import dac_bank_pkg::*;
#(
  parameter int N_UNI = 4,
  parameter int N_BI = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h30,
  localparam int N_CH = N_UNI + N_BI,
  localparam int CODE_W = DATA_W - CODE_LSB
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   ldac_n,
  input  logic                   closed_loop,
  output logic [N_CH*CODE_W-1:0] code_o,
  output logic [N_CH*2-1:0]      span_o,
  output logic [N_CH-1:0]        pending_o
);
  logic [N_CH-1:0]   we;
  logic              xfer;
  logic [CODE_W-1:0] f_code;
  logic [1:0]        f_span;
  logic              f_load, f_copy;

  assign wr_ready = 1'b1;
  assign f_code = wr_data[DATA_W-1:CODE_LSB];
  assign f_span = wr_data[SPAN_LSB+1:SPAN_LSB];
  assign f_load = wr_data[LOAD_BIT];
  assign f_copy = wr_data[COPY_BIT];

  dac_strobe_sync u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(ldac_n), .fall(xfer)
  );

  dac_addr_decode #(
    .N_UNI(N_UNI), .N_BI(N_BI), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .copy(f_copy), .closed_loop(closed_loop), .we(we)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    dac_chan_reg #(.CODE_W(CODE_W), .IS_BI(i >= N_UNI)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(we[i]), .wr_load(f_load), .wr_code(f_code), .wr_span(f_span),
      .xfer(xfer),
      .act_code(code_o[i*CODE_W +: CODE_W]),
      .act_span(span_o[i*2 +: 2]),
      .pend(pending_o[i])
    );

    if (i >= N_UNI) begin : g_bchk
      // R5
      bcast_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && f_copy && !f_load && !closed_loop &&
         (wr_addr >= ADDR_W'(BASE_ADDR + N_UNI)) &&
         (wr_addr <= ADDR_W'(BASE_ADDR + N_CH - 1)))
        |=> (code_o[i*CODE_W +: CODE_W] == $past(f_code)));
    end
  end

  // R10
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
  // R7
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !xfer &&
     ((wr_addr < BASE_ADDR) || (wr_addr > ADDR_W'(BASE_ADDR + N_CH - 1))))
    |=> $stable(code_o) && $stable(pending_o) && $stable(span_o));
endmodule

// File: tb/dac_code_bank_tb.sv
module dac_code_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ldac_n = 1'b1;
  logic        closed_loop = 1'b0;
  logic [95:0] code_o;
  logic [15:0] span_o;
  logic [7:0]  pending_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [11:0] m_stg [8];
  logic [11:0] m_act [8];
  logic [1:0]  m_sstg [8];
  logic [1:0]  m_sact [8];
  logic [7:0]  m_pend;

  always #4 clk = ~clk;

  dac_code_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .ldac_n(ldac_n),
    .closed_loop(closed_loop), .code_o(code_o), .span_o(span_o),
    .pending_o(pending_o)
  );

  function automatic logic [7:0] hit_mask(logic [7:0] a, logic cp, logic cl);
    logic [7:0] m = '0;
    if (a >= 8'h30 && a <= 8'h37) begin
      m[a - 8'h30] = 1'b1;
      if (cp && !cl && a >= 8'h34) m = m | 8'hF0;
    end
    return m;
  endfunction

  function automatic void model_write(logic [7:0] m, logic [11:0] c, logic [1:0] s, logic ld);
    for (int i = 0; i < 8; i++) begin
      if (m[i]) begin
        m_stg[i] = c;
        if (i >= 4 && s != 2'b11) m_sstg[i] = s;
        if (!ld) begin
          m_act[i] = c; m_sact[i] = m_sstg[i]; m_pend[i] = 1'b0;
        end else m_pend[i] = 1'b1;
      end
    end
  endfunction

  function automatic void model_xfer(logic [7:0] excl);
    for (int i = 0; i < 8; i++) begin
      if (m_pend[i] && !excl[i]) begin
        m_act[i] = m_stg[i]; m_sact[i] = m_sstg[i]; m_pend[i] = 1'b0;
      end
    end
  endfunction

  task automatic check_all(string tag);
    logic [95:0] ec;
    logic [15:0] es;
    for (int i = 0; i < 8; i++) begin
      ec[i*12 +: 12] = m_act[i];
      es[i*2 +: 2] = m_sact[i];
    end
    n_chk++;
    if (code_o !== ec || span_o !== es || pending_o !== m_pend || wr_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: code=%h span=%h pend=%h rdy=%b exp code=%h span=%h pend=%h rdy=1",
               tag, code_o, span_o, pending_o, wr_ready, ec, es, m_pend);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [11:0] c, logic [1:0] s,
                          logic ld, logic cp, string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = {c, s, ld, cp};
    @(posedge clk);
    model_write(hit_mask(a, cp, closed_loop), c, s, ld);
    @(negedge clk);
    wr_valid = 1'b0;
    check_all(tag);
  endtask

  task automatic strobe(string tag);
    @(negedge clk); ldac_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); check_all({tag, " R4 before third edge"});
    @(posedge clk); model_xfer('0);
    @(negedge clk); check_all({tag, " R4 transfer"});
    repeat (3) @(negedge clk);
    check_all({tag, " R4 held low no retransfer"});
    ldac_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_stg[i] = '0; m_act[i] = '0; m_sstg[i] = '0; m_sact[i] = '0;
    end
    m_pend = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset state");

    // R2 R7: address sweep with direct loads, expected codes from arithmetic
    for (int a = 8'h28; a < 8'h40; a++) begin
      logic [11:0] c;
      c = 12'((a * 37 + 5) * 11);
      do_write(8'(a), c, 2'(a % 3), 1'b0, 1'b0, "R2 R7 address sweep");
    end

    // R9: every span code on every bipolar channel, including keep (11)
    for (int ch = 0; ch < 8; ch++)
      for (int s = 0; s < 4; s++)
        do_write(8'(8'h30 + ch), 12'(ch * 256 + s * 17), 2'(s), 1'b0, 1'b0, "R9 span sweep");

    // R3: deferred loads stay pending, live codes unchanged
    for (int ch = 0; ch < 8; ch += 2)
      do_write(8'(8'h30 + ch), 12'(4095 - ch * 100), 2'b01, 1'b1, 1'b0, "R3 deferred");
    strobe("deferred set");

    // R5: broadcast in open loop, direct and deferred
    do_write(8'h35, 12'hA5C, 2'b10, 1'b0, 1'b1, "R5 broadcast direct");
    do_write(8'h37, 12'h3C3, 2'b01, 1'b1, 1'b1, "R5 broadcast deferred");
    strobe("R5 broadcast");

    // R6: copy flag in closed loop and on unipolar addresses
    closed_loop = 1'b1;
    do_write(8'h36, 12'h777, 2'b00, 1'b0, 1'b1, "R6 closed loop copy ignored");
    closed_loop = 1'b0;
    do_write(8'h32, 12'h123, 2'b00, 1'b0, 1'b1, "R6 unipolar copy ignored");

    // R8: write collides with transfer on channel 2; channel 5 transfers
    do_write(8'h32, 12'h456, 2'b00, 1'b1, 1'b0, "R8 setup");
    do_write(8'h35, 12'h654, 2'b10, 1'b1, 1'b0, "R8 setup");
    @(negedge clk); ldac_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 8'h32; wr_data = {12'hBEE, 2'b00, 1'b0, 1'b0};
    @(posedge clk);
    model_xfer(8'h04);
    model_write(8'h04, 12'hBEE, 2'b00, 1'b0);
    @(negedge clk); wr_valid = 1'b0;
    check_all("R8 write wins over transfer");
    ldac_n = 1'b1;
    repeat (4) @(negedge clk);

    do_write(8'h31, 12'h0F0, 2'b00, 1'b1, 1'b0, "R8 collide pending");
    @(negedge clk); ldac_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 8'h31; wr_data = {12'hDAD, 2'b00, 1'b1, 1'b0};
    @(posedge clk);
    model_xfer(8'h02);
    model_write(8'h02, 12'hDAD, 2'b00, 1'b1);
    @(negedge clk); wr_valid = 1'b0;
    check_all("R8 deferred write keeps pending");
    ldac_n = 1'b1;
    repeat (4) @(negedge clk);
    strobe("R8 final");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule